// File: doc/BRIEF.md
# Two-Wire Management Slave

This block is the slave end of a two-wire management link in the style of the MII management frame. The link clock (`mdc`) is the block clock, and the shared data line is split into an input (`mdio_in`) and a driven bit with an output enable (`mdio_out`, `mdio_oe`). The tri-state buffer and the pull-up are outside the block. A frame needs no preamble. It carries a start pattern, a two-bit opcode, a five-bit device address, a five-bit register address, two turnaround bits and a sixteen-bit data field.

The slave answers only frames whose device address equals the value that was on the strap pins while reset was held. A write places the low byte of the data field into one of a small bank of 8-bit registers, and the block pulses a one-hot strobe carrying that byte. A read returns the selected register in the low byte of the data field with the high byte zero. The slave drives the line only in the second turnaround cycle and the sixteen data cycles.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised from the pattern 0 then 1 on `mdio_in` with no preamble. Any number of idle ones, or extra zeros, before the final 0,1 pair is accepted.
- R2: The opcode bits, first bit first, are 1,0 for a read and 0,1 for a write. Opcodes 0,0 and 1,1 end the frame: the block does not drive and no register changes.
- R3: The device address is the value of `strap_addr` at the last clock with `rst_n` low. Later changes of `strap_addr` have no effect until the next reset.
- R4: When the device address differs from the latched one, `mdio_oe` stays 0 and no strobe fires for the rest of that frame. Its remaining 23 bits are skipped and are not parsed as a new start.
- R5: In a matching read, `mdio_oe` is 0 during the first turnaround cycle. In the second turnaround cycle `mdio_oe` is 1 and `mdio_out` is 0, as seen at that rising edge.
- R6: In a matching read, the 16 data cycles carry the selected register, most significant bit first, with bits 15:8 equal to 0.
- R7: In a matching write, the received bits 7:0 go into the addressed register when the 16th data bit is sampled, and bits 15:8 are discarded. In the following cycle `wr_stb` has exactly bit N set, N being the register address, and `wr_data` holds the byte.
- R8: `mdio_oe` returns to 0 in the cycle after the last data bit is sampled. The bus then idles high.
- R9: Register addresses at or above `NUM_REGS` (8 by default) read as zero. Writes to them change nothing and raise no strobe.
- R10: A clock with `rst_n` low clears every register to 0 and sets `mdio_oe` and `wr_stb` to 0.
- R11: A new frame may start on the clock right after the last data bit of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 5 | Device address straps, captured while reset is low |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_out | output | 1 | Bit the slave drives when enabled |
| mdio_oe | output | 1 | Output enable for the data line buffer |
| wr_stb | output | 8 | One-hot write strobe, one bit per register |
| wr_data | output | 8 | Byte written, valid while a strobe bit is high |

## Verification
The assertions assume the master releases the line for the whole read turnaround-plus-data window, so the slave never competes with a master-driven level. They also assume `mdio_in` changes only between rising edges. The bench drives every bit at the falling edge and models the line as the slave's bit when enabled, otherwise the master's bit, otherwise a pulled-up one. This keeps the parser input inside those assumptions. The random frames use only legal read and write opcodes with full-length fields. Aborted opcodes are sent as directed short frames followed by idle ones, since an aborted frame hands the line straight back to the start hunt.

// File: rtl/mdio_pkg.sv
// Package: shared encodings for the two-wire management slave.
// Assumes: one frame layout with 2-bit opcode and fixed field order.
package mdio_pkg;

    // Opcode values as received, first bit in the MSB.
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    // Frame parser states.
    typedef enum logic [2:0] {
        PS_HUNT,
        PS_START,
        PS_OPCODE,
        PS_DEVADR,
        PS_REGADR,
        PS_TURN,
        PS_DATA,
        PS_SKIP
    } parse_st_t;

    // Read shifter phases.
    typedef enum logic [1:0] {
        SH_OFF,
        SH_TURN,
        SH_DATA
    } shift_ph_t;

endpackage

// File: rtl/mdio_frame_parser.sv
// Module: mdio_frame_parser
// Walks the incoming bit stream field by field. It latches the device
// address from the straps during reset, raises rd_start at the first
// turnaround edge of a matching read, and raises wr_req at the last data
// edge of a matching write.
// Assumes: mdio_in is stable around each rising edge of clk.
module mdio_frame_parser
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              mdio_in,
    output logic              rd_start,
    output logic              wr_req,
    output logic [ADDR_W-1:0] reg_sel,
    output logic [REG_W-1:0]  wr_byte,
    output logic              hunting,
    output logic              skipping
);

    localparam int SKIP_LEN = ADDR_W + 2 + DATA_W;
    localparam int CNT_W    = $clog2(SKIP_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SKP = CNT_W'(SKIP_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    parse_st_t          st;
    logic [CNT_W-1:0]   cnt;
    logic               op_first;
    logic               is_read;
    logic [ADDR_W-1:0]  dev_addr;
    logic [ADDR_W-1:0]  adr_sh;
    logic [REG_W-1:0]   byte_sh;
    logic [ADDR_W-1:0]  adr_next;
    logic [REG_W-1:0]   byte_next;
    logic [1:0]         op_now;

    // Next values of the field shift registers, including the bit on the line.
    always_comb begin
        adr_next  = {adr_sh[ADDR_W-2:0], mdio_in};
        byte_next = {byte_sh[REG_W-2:0], mdio_in};
        op_now    = {op_first, mdio_in};
    end

    // Request pulses decoded from the state at the sampling edge.
    always_comb begin
        rd_start = (st == PS_TURN) && (cnt == '0) && is_read;
        wr_req   = (st == PS_DATA) && (cnt == LAST_DAT) && !is_read;
        wr_byte  = byte_next;
        hunting  = (st == PS_HUNT);
        skipping = (st == PS_SKIP);
    end

    // Device address capture: follows the straps only while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_addr <= strap_addr;
    end

    // Field sequencer: one bit per clock, counter tracks position in field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_HUNT;
            cnt      <= '0;
            op_first <= 1'b0;
            is_read  <= 1'b0;
            adr_sh   <= '0;
            byte_sh  <= '0;
            reg_sel  <= '0;
        end else begin
            case (st)
                PS_HUNT: begin
                    if (!mdio_in) st <= PS_START;
                end
                PS_START: begin
                    if (mdio_in) begin
                        st  <= PS_OPCODE;
                        cnt <= '0;
                    end
                end
                PS_OPCODE: begin
                    if (cnt == '0) begin
                        op_first <= mdio_in;
                        cnt      <= CNT_ONE;
                    end else begin
                        cnt <= '0;
                        if (op_now == OPC_READ) begin
                            is_read <= 1'b1;
                            st      <= PS_DEVADR;
                        end else if (op_now == OPC_WRITE) begin
                            is_read <= 1'b0;
                            st      <= PS_DEVADR;
                        end else begin
                            st <= PS_HUNT;
                        end
                    end
                end
                PS_DEVADR: begin
                    adr_sh <= adr_next;
                    if (cnt == LAST_ADR) begin
                        cnt <= '0;
                        st  <= (adr_next == dev_addr) ? PS_REGADR : PS_SKIP;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                PS_REGADR: begin
                    adr_sh <= adr_next;
                    if (cnt == LAST_ADR) begin
                        cnt     <= '0;
                        reg_sel <= adr_next;
                        st      <= PS_TURN;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                PS_TURN: begin
                    if (cnt == '0) begin
                        cnt <= CNT_ONE;
                    end else begin
                        cnt <= '0;
                        st  <= PS_DATA;
                    end
                end
                PS_DATA: begin
                    byte_sh <= byte_next;
                    if (cnt == LAST_DAT) begin
                        cnt <= '0;
                        st  <= PS_HUNT;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                PS_SKIP: begin
                    if (cnt == LAST_SKP) begin
                        cnt <= '0;
                        st  <= PS_HUNT;
                    end else begin
                        cnt <= cnt + CNT_ONE;
                    end
                end
                default: st <= PS_HUNT;
            endcase
        end
    end

    // R2: an opcode whose two bits are equal sends the parser back to hunting.
    a_r2_bad_opcode_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_OPCODE && cnt == CNT_ONE && op_first == mdio_in) |=> (st == PS_HUNT));

    // R3: once out of reset the latched device address never moves.
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(dev_addr));

endmodule

// File: rtl/mdio_read_shifter.sv
// Module: mdio_read_shifter
// Owns the line driver. On rd_start it enables the output with a zero for
// the second turnaround cycle, then shifts a 16-bit word out MSB first,
// changing the bit just after each rising edge, and releases afterwards.
// Assumes: rd_start arrives at the first turnaround edge of a read.
module mdio_read_shifter
    import mdio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic [REG_W-1:0] rd_byte,
    output logic             mdio_out,
    output logic             mdio_oe
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    shift_ph_t         ph;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;

    // Driver sequence: turnaround zero, then DATA_W bits, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= SH_OFF;
            cnt      <= '0;
            sh       <= '0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            case (ph)
                SH_OFF: begin
                    if (rd_start) begin
                        ph       <= SH_TURN;
                        sh       <= {{(DATA_W-REG_W){1'b0}}, rd_byte};
                        mdio_out <= 1'b0;
                        mdio_oe  <= 1'b1;
                    end
                end
                SH_TURN: begin
                    mdio_out <= sh[DATA_W-1];
                    sh       <= {sh[DATA_W-2:0], 1'b0};
                    cnt      <= '0;
                    ph       <= SH_DATA;
                end
                SH_DATA: begin
                    if (cnt == LAST_BIT) begin
                        mdio_oe  <= 1'b0;
                        mdio_out <= 1'b0;
                        ph       <= SH_OFF;
                    end else begin
                        mdio_out <= sh[DATA_W-1];
                        sh       <= {sh[DATA_W-2:0], 1'b0};
                        cnt      <= cnt + CNT_ONE;
                    end
                end
                default: ph <= SH_OFF;
            endcase
        end
    end

    // R5: the first driven cycle of a read always shows a zero.
    a_r5_turn_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R6: a read start is only taken while the driver is idle.
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> !mdio_oe);

endmodule

// File: rtl/mdio_reg_bank.sv
// Module: mdio_reg_bank
// Holds NUM_REGS byte registers, gives the addressed one to the read path
// (zero when out of range) and raises a registered one-hot write strobe.
// Assumes: wr_req is a single-cycle pulse with reg_sel stable.
module mdio_reg_bank #(
    parameter int ADDR_W   = 5,
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_sel,
    input  logic                wr_req,
    input  logic [REG_W-1:0]    wr_byte,
    output logic [REG_W-1:0]    rd_byte,
    output logic [NUM_REGS-1:0] wr_stb,
    output logic [REG_W-1:0]    wr_data
);

    logic [REG_W-1:0]    regs [NUM_REGS];
    logic [NUM_REGS-1:0] hit;

    // Per-register write decode.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g] = wr_req && (reg_sel == ADDR_W'(g));
    end

    // Read select; addresses past the bank return zero.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_sel == ADDR_W'(i)) rd_byte = regs[i];
        end
    end

    // Register storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (hit[i]) regs[i] <= wr_byte;
            end
        end
    end

    // Strobe and byte outputs, one cycle after the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= hit;
            if (wr_req) wr_data <= wr_byte;
        end
    end

    // R7: at most one register strobed per cycle.
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    // R7: a strobe follows only a write request.
    a_r7_stb_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |-> $past(wr_req));

endmodule

// File: rtl/mdio_mgmt_slave.sv
// Module: mdio_mgmt_slave
// Top of the two-wire management slave: parser, read shifter, register bank.
// Assumes: the external buffer drives the line from mdio_out when mdio_oe
// is high, and a pull-up holds it high otherwise.
module mdio_mgmt_slave #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 8
) (
    input  logic                mdc,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   strap_addr,
    input  logic                mdio_in,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic [NUM_REGS-1:0] wr_stb,
    output logic [REG_W-1:0]    wr_data
);

    logic              rd_start;
    logic              wr_req;
    logic [ADDR_W-1:0] reg_sel;
    logic [REG_W-1:0]  wr_byte;
    logic [REG_W-1:0]  rd_byte;
    logic              hunting;
    logic              skipping;

    mdio_frame_parser #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .REG_W (REG_W)
    ) u_parser (
        .clk       (mdc),
        .rst_n     (rst_n),
        .strap_addr(strap_addr),
        .mdio_in   (mdio_in),
        .rd_start  (rd_start),
        .wr_req    (wr_req),
        .reg_sel   (reg_sel),
        .wr_byte   (wr_byte),
        .hunting   (hunting),
        .skipping  (skipping)
    );

    mdio_reg_bank #(
        .ADDR_W  (ADDR_W),
        .REG_W   (REG_W),
        .NUM_REGS(NUM_REGS)
    ) u_bank (
        .clk    (mdc),
        .rst_n  (rst_n),
        .reg_sel(reg_sel),
        .wr_req (wr_req),
        .wr_byte(wr_byte),
        .rd_byte(rd_byte),
        .wr_stb (wr_stb),
        .wr_data(wr_data)
    );

    mdio_read_shifter #(
        .DATA_W(DATA_W),
        .REG_W (REG_W)
    ) u_shift (
        .clk     (mdc),
        .rst_n   (rst_n),
        .rd_start(rd_start),
        .rd_byte (rd_byte),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe)
    );

    // R4: while a foreign frame is skipped the line is never driven.
    a_r4_quiet_on_skip: assert property (@(posedge mdc) disable iff (!rst_n)
        skipping |-> !mdio_oe);

    // R8: the driver lets go exactly when the parser is back at the hunt.
    a_r8_release_idle: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> hunting);

    // R7: a write completion never coincides with a driven line.
    a_r7_write_no_drive: assert property (@(posedge mdc) disable iff (!rst_n)
        (wr_stb != '0) |-> !mdio_oe);

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;

    localparam int NREG = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = 5'h0B;
    logic       m_oe = 1'b0;
    logic       m_bit = 1'b1;
    logic       dut_out, dut_oe;
    logic [NREG-1:0] wr_stb;
    logic [7:0] wr_data;
    wire        line = dut_oe ? dut_out : (m_oe ? m_bit : 1'b1);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [4:0] my_addr;
    logic [7:0] model [32];
    logic       oe_log [32];
    logic       out_log [32];
    logic       post_oe;
    logic [NREG-1:0] post_stb;
    logic [7:0] post_wd;

    always #10 clk = ~clk;

    mdio_mgmt_slave u_dut (
        .mdc       (clk),
        .rst_n     (rst_n),
        .strap_addr(strap),
        .mdio_in   (line),
        .mdio_out  (dut_out),
        .mdio_oe   (dut_oe),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] ra);
        return (ra < NREG) ? {8'h00, model[ra]} : 16'h0000;
    endfunction

    function automatic logic [NREG-1:0] exp_stb(input logic [4:0] ra);
        return (ra < NREG) ? (NREG'(1) << ra) : '0;
    endfunction

    // Reset with given straps; entered and left at a falling edge.
    task automatic do_reset(input logic [4:0] s);
        rst_n = 1'b0;
        strap = s;
        m_oe  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        my_addr = s;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
    endtask

    task automatic idle(input int n);
        m_oe = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // One full 32-bit frame; logs what the master would see at each edge.
    task automatic do_frame(input logic [1:0] op, input logic [4:0] dev,
                            input logic [4:0] ra, input logic [15:0] wd);
        logic [31:0] fr;
        bit is_rd;
        is_rd = (op == 2'b10);
        fr = {2'b01, op, dev, ra, (is_rd ? 2'b11 : 2'b10), wd};
        for (int k = 0; k < 32; k++) begin
            oe_log[k]  = dut_oe;
            out_log[k] = dut_out;
            m_oe  = !(is_rd && k >= 14);
            m_bit = fr[31-k];
            @(posedge clk);
            @(negedge clk);
        end
        m_oe     = 1'b0;
        post_oe  = dut_oe;
        post_stb = wr_stb;
        post_wd  = wr_data;
    endtask

    // Frame plus all checks against the model.
    task automatic frame_chk(input logic [1:0] op, input logic [4:0] dev,
                             input logic [4:0] ra, input logic [15:0] wd);
        bit match, any_oe, pre_oe, data_oe;
        logic [15:0] rd, er;
        match = (dev == my_addr);
        er = exp_read(ra);
        do_frame(op, dev, ra, wd);
        any_oe = post_oe;
        for (int k = 0; k < 32; k++) any_oe |= oe_log[k];
        if (!match) begin
            chk(!any_oe, "R4", any_oe, 0, "line driven on foreign frame");
            chk(post_stb == 0, "R4", post_stb, 0, "strobe on foreign frame");
        end else if (op == 2'b10) begin
            pre_oe = 0;
            for (int k = 0; k < 15; k++) pre_oe |= oe_log[k];
            chk(!pre_oe, "R5", pre_oe, 0, "driven before second turnaround");
            chk(oe_log[15] && !out_log[15], "R5", {oe_log[15], out_log[15]}, 2'b10,
                "second turnaround oe/out");
            data_oe = 1;
            rd = '0;
            for (int k = 16; k < 32; k++) begin
                data_oe &= oe_log[k];
                rd[31-k] = out_log[k];
            end
            chk(data_oe && rd == er, "R6", rd, er, "read data");
            chk(!post_oe, "R8", post_oe, 0, "oe after last data bit");
            chk(post_stb == 0, "R6", post_stb, 0, "strobe on read");
        end else begin
            chk(!any_oe, "R7", any_oe, 0, "line driven on write");
            chk(post_stb == exp_stb(ra), "R7", post_stb, exp_stb(ra), "write strobe");
            if (ra < NREG) begin
                chk(post_wd == wd[7:0], "R7", post_wd, wd[7:0], "write byte");
                model[ra] = wd[7:0];
            end
        end
    endtask

    // Short aborted frame: start, bad opcode, then idle ones.
    task automatic abort_chk(input logic [1:0] op);
        logic [3:0] bits;
        bit any;
        bits = {2'b01, op};
        any = 0;
        for (int k = 0; k < 4; k++) begin
            m_oe = 1'b1;
            m_bit = bits[3-k];
            @(posedge clk);
            @(negedge clk);
            any |= dut_oe | (wr_stb != 0);
        end
        m_oe = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            any |= dut_oe | (wr_stb != 0);
        end
        chk(!any, "R2", any, 0, "activity after bad opcode");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(5'h0B);
        // R10: reset state at the outputs
        chk(!dut_oe && wr_stb == 0, "R10", {dut_oe, wr_stb}, 0, "outputs after reset");
        // R3: straps change after release and must be ignored
        strap = 5'h03;
        // R1: frame straight after reset, no preamble
        frame_chk(2'b10, 5'h0B, 5'd2, 16'h0);
        // R10: registers reset to zero (checked as read data)
        frame_chk(2'b10, 5'h0B, 5'd7, 16'h0);
        // R11: back-to-back write then read
        frame_chk(2'b01, 5'h0B, 5'd3, 16'hA55C);
        frame_chk(2'b10, 5'h0B, 5'd3, 16'h0);
        // R3: address from changed straps is not answered
        frame_chk(2'b10, 5'h03, 5'd3, 16'h0);
        frame_chk(2'b01, 5'h03, 5'd3, 16'h0011);
        frame_chk(2'b10, 5'h0B, 5'd3, 16'h0);
        // R1: long preamble of ones, then extra zeros before the start
        idle(9);
        m_oe = 1'b1; m_bit = 1'b0;
        repeat (3) @(negedge clk);
        frame_chk(2'b01, 5'h0B, 5'd0, 16'hFF81);
        frame_chk(2'b10, 5'h0B, 5'd0, 16'h0);
        // R2: both illegal opcodes abort, state unchanged afterwards
        abort_chk(2'b00);
        abort_chk(2'b11);
        frame_chk(2'b10, 5'h0B, 5'd0, 16'h0);
        // R4: foreign frame with start-like patterns in its data
        frame_chk(2'b01, 5'h0A, 5'd1, 16'h5151);
        frame_chk(2'b10, 5'h0B, 5'd1, 16'h0);
        // R9: out-of-range register write and read
        frame_chk(2'b01, 5'h0B, 5'd26, 16'h00EE);
        frame_chk(2'b10, 5'h0B, 5'd26, 16'h0);
        frame_chk(2'b01, 5'h0B, 5'd8, 16'h0077);
        frame_chk(2'b10, 5'h0B, 5'd8, 16'h0);
        // R6/R7: random legal traffic
        for (int n = 0; n < 80; n++) begin
            logic [1:0] op;
            logic [4:0] dev, ra;
            logic [15:0] wd;
            op  = ($urandom % 2) ? 2'b10 : 2'b01;
            dev = ($urandom % 4 == 0) ? (my_addr ^ 5'(1 + $urandom % 31)) : my_addr;
            ra  = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % NREG);
            wd  = 16'($urandom);
            if ($urandom % 3 == 0) idle(1 + $urandom % 4);
            frame_chk(op, dev, ra, wd);
        end
        // R10/R3: second reset clears bank and takes new straps (edge value 31)
        do_reset(5'h1F);
        frame_chk(2'b10, 5'h1F, 5'd3, 16'h0);
        frame_chk(2'b10, 5'h0B, 5'd3, 16'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule